// File: doc/BRIEF.md
# Memory Mapper Register Readback Gate

This block holds the page registers of a memory mapper on an 8-bit CPU I/O bus and decides whether CPU reads of those registers get an answer. A write strobe at one of the register addresses stores the full data byte into the selected register. A read strobe at one of those addresses returns the stored byte, but only when the readback gate is open. The gate is set by a software mode value, which has three settings: off, on, and automatic.

In automatic mode, firmware probes the bus. It writes zero to a page register and reads it back. If the read returns zero, some other mapper on the bus already answers, and firmware records that result in a status flag through a control strobe. The block then answers reads only while that flag shows no other responder.

When the gate opens, the block raises `drive_en` for the external level-shifted transceiver and drives all eight data lines together. It never drives only part of the byte. When it does not drive, the bus is released, so the bus pull-ups return 0xFF to the CPU. The CPU bus uses plain strobes, so there is no valid/ready handshake and no back-pressure: every strobe is taken in the cycle it is seen.

Top module: `mapper_readback_gate`

## Requirements
- R1: After reset, all page registers hold 0x00, the mode is automatic (2), the other-responder flag is set, and `drive_en` is low for every read.
- R2: A cycle with `io_wr` high and an address from BASE_ADDR (0xFC) to BASE_ADDR+3 stores all 8 bits of `io_wdata` into the register selected by address bits [1:0]. The new value is visible from the next cycle. A write to any other address changes no register.
- R3: A cycle with `mode_wr` high loads `mode_wdata` as the mode from the next cycle on: 0 means off, 1 means on, 2 means automatic. The value 3 is ignored and leaves the mode unchanged.
- R4: In mode 0, `drive_en` stays low for every read.
- R5: In mode 1, a read strobe at a register address raises `drive_en` in the same cycle, and `rd_data` carries all 8 bits of the selected register.
- R6: In mode 2, reads are answered as in R5 only while the other-responder flag is 0. `probe_wr` loads the flag from `probe_wdata` for the next cycle, where 1 means another mapper answers.
- R7: `drive_en` is low in any cycle where `io_rd` is low or the address misses the register range. Whenever `drive_en` is low, `rd_data` is 0x00.
- R8: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | CPU I/O address |
| io_wdata | input | 8 | CPU write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| mode_wr | input | 1 | Load strobe for the mode value |
| mode_wdata | input | 2 | Mode value: 0 off, 1 on, 2 automatic |
| probe_wr | input | 1 | Load strobe for the probe result flag |
| probe_wdata | input | 1 | Probe result, 1 = another mapper answers |
| rd_data | output | 8 | Read data toward the transceiver, 0 when not driving |
| drive_en | output | 1 | Output enable for all eight data lines |

## Verification
The assertions check on every cycle that a register write lands in the selected register, that a mode load takes effect and the reserved value 3 is ignored, that mode 0 never drives, that mode 1 always drives on a matching read, and that released cycles carry zero data. Only the bench's scenarios can show the byte values read back after sequences of writes, the effect of the probe flag over a full sequence of firmware steps, and the same-cycle read and write ordering. The bench compares the outputs against its own model in every cycle.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ON   = 2'd1,
    MODE_AUTO = 2'd2
  } mode_e;
endpackage

// File: rtl/mrg_page_file.sv
module mrg_page_file #(
  parameter int NUM_PAGES = 4,
  parameter int DATA_W    = 8,
  localparam int SEL_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  sel,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_PAGES-1:0][DATA_W-1:0]  pages_q
);
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n)
        pages_q[g] <= '0;
      else if (wr_en && (sel == SEL_W'(g)))
        pages_q[g] <= wdata;
    end
  end

  // R2
  page_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pages_q[$past(sel)] == $past(wdata));
endmodule

// File: rtl/mrg_ctrl.sv
module mrg_ctrl
  import mrg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       probe_wr,
  input  logic       probe_wdata,
  output mode_e      mode_q,
  output logic       peer_seen_q,
  output logic       gate_open
);
  logic mode_legal;
  assign mode_legal = (mode_wdata != 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_AUTO;
      peer_seen_q <= 1'b1;
    end else begin
      if (mode_wr && mode_legal) mode_q <= mode_e'(mode_wdata);
      if (probe_wr)              peer_seen_q <= probe_wdata;
    end
  end

  always_comb begin
    unique case (mode_q)
      MODE_ON:   gate_open = 1'b1;
      MODE_AUTO: gate_open = !peer_seen_q;
      default:   gate_open = 1'b0;
    endcase
  end

  // R3
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata != 2'd3) |=> mode_q == $past(mode_wdata));
  // R3
  mode_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata == 2'd3) |=> $stable(mode_q));
  // R6
  probe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_wr |=> peer_seen_q == $past(probe_wdata));
endmodule

// File: rtl/mapper_readback_gate.sv
module mapper_readback_gate
  import mrg_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              NUM_PAGES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic              probe_wr,
  input  logic              probe_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              drive_en
);
  localparam int SEL_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  logic [NUM_PAGES-1:0][DATA_W-1:0] pages;
  logic [SEL_W-1:0] sel;
  logic             hit;
  mode_e            mode;
  logic             peer_seen;
  logic             gate_open;

  assign sel = io_addr[SEL_W-1:0];
  assign hit = (io_addr[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);

  mrg_page_file #(.NUM_PAGES(NUM_PAGES), .DATA_W(DATA_W)) u_pages (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (io_wr && hit),
    .sel     (sel),
    .wdata   (io_wdata),
    .pages_q (pages)
  );

  mrg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_wdata  (mode_wdata),
    .probe_wr    (probe_wr),
    .probe_wdata (probe_wdata),
    .mode_q      (mode),
    .peer_seen_q (peer_seen),
    .gate_open   (gate_open)
  );

  assign drive_en = io_rd && hit && gate_open;
  assign rd_data  = drive_en ? pages[sel] : '0;

  // R4
  off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> !drive_en);
  // R5
  on_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ON && io_rd && hit) |-> drive_en);
  // R6
  auto_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_AUTO && peer_seen) |-> !drive_en);
  // R7
  release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> rd_data == '0);
  // R7
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> !drive_en);
endmodule

// File: tb/tb_mapper_readback_gate.sv
module tb_mapper_readback_gate;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] io_addr = 0, io_wdata = 0;
  logic       io_wr = 0, io_rd = 0, mode_wr = 0, probe_wr = 0, probe_wdata = 0;
  logic [1:0] mode_wdata = 0;
  logic [7:0] rd_data;
  logic       drive_en;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_page [4];
  int m_mode;
  int m_peer;

  always #2 clk = ~clk;

  mapper_readback_gate dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .probe_wr(probe_wr), .probe_wdata(probe_wdata),
    .rd_data(rd_data), .drive_en(drive_en)
  );

  // reference model: state update at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_page[i]) m_page[i] = 0;
      m_mode = 2;
      m_peer = 1;
    end else begin
      if (io_wr && io_addr >= 8'hFC) m_page[io_addr - 8'hFC] = io_wdata;
      if (mode_wr && mode_wdata != 2'd3) m_mode = mode_wdata;
      if (probe_wr) m_peer = probe_wdata;
    end
  end

  task automatic cyc(input logic [7:0] a, input logic [7:0] d, input bit wr, input bit rd,
                     input bit mw, input logic [1:0] md, input bit pw, input bit pd,
                     input string tag);
    bit exp_en;
    int exp_d;
    io_addr = a; io_wdata = d; io_wr = wr; io_rd = rd;
    mode_wr = mw; mode_wdata = md; probe_wr = pw; probe_wdata = pd;
    #1;
    exp_en = rd && (a >= 8'hFC) && (m_mode == 1 || (m_mode == 2 && m_peer == 0));
    exp_d  = exp_en ? m_page[a - 8'hFC] : 0;
    tests++;
    if (drive_en !== exp_en || rd_data !== 8'(exp_d)) begin
      fails++;
      $display("FAIL %s: drive_en=%0b rd_data=%02h, expected drive_en=%0b rd_data=%02h",
               tag, drive_en, rd_data, exp_en, exp_d);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(a, 8'h00, 0, 1, 0, 2'd0, 0, 0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    cyc(a, d, 1, 0, 0, 2'd0, 0, 0, tag);
  endtask
  task automatic setmode(input logic [1:0] m, input string tag);
    cyc(8'h00, 8'h00, 0, 0, 1, m, 0, 0, tag);
  endtask
  task automatic setpeer(input bit p, input string tag);
    cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, p, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: auto mode with peer flag set -> silent
    for (int k = 0; k < 4; k++) rd(8'hFC + 8'(k), "R1 reset silent");
    setmode(2'd1, "R3 mode on");
    for (int k = 0; k < 4; k++) rd(8'hFC + 8'(k), "R1 reset page zero");
    // R2/R5 patterns
    wr(8'hFC, 8'hA5, "R2 write p0");
    wr(8'hFD, 8'h5A, "R2 write p1");
    wr(8'hFE, 8'hFF, "R2 write p2");
    wr(8'hFF, 8'h81, "R2 write p3");
    for (int k = 0; k < 4; k++) rd(8'hFC + 8'(k), "R5 readback all bits");
    wr(8'hFB, 8'h33, "R2 miss write");
    wr(8'h00, 8'h44, "R2 miss write low");
    for (int k = 0; k < 4; k++) rd(8'hFC + 8'(k), "R2 miss left pages");
    // R7
    rd(8'hFB, "R7 address miss");
    cyc(8'hFD, 8'h00, 0, 0, 0, 2'd0, 0, 0, "R7 no strobe");
    // R8
    cyc(8'hFE, 8'h12, 1, 1, 0, 2'd0, 0, 0, "R8 same cycle old value");
    rd(8'hFE, "R8 new value next cycle");
    // R4
    setmode(2'd0, "R3 mode off");
    for (int k = 0; k < 4; k++) rd(8'hFC + 8'(k), "R4 off silent");
    setmode(2'd3, "R3 reserved");
    rd(8'hFC, "R3 reserved ignored");
    // R6
    setmode(2'd2, "R3 mode auto");
    rd(8'hFD, "R6 auto peer present");
    setpeer(0, "R6 clear peer");
    rd(8'hFD, "R6 auto no peer");
    cyc(8'hFC, 8'h00, 1, 0, 0, 2'd0, 0, 0, "R6 probe write zero");
    rd(8'hFC, "R6 probe readback");
    setpeer(1, "R6 set peer");
    rd(8'hFC, "R6 auto silenced");
    setmode(2'd1, "R3 back on");
    setmode(2'd3, "R3 reserved while on");
    rd(8'hFF, "R3 reserved keeps on");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = ($urandom % 3 == 0) ? 8'($urandom) : 8'hFC + 8'($urandom % 4);
      cyc(a, 8'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8 == 0),
          2'($urandom), ($urandom % 8 == 0), 1'($urandom), "R2 R5 R6 R7 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule